// File: doc/BRIEF.md
# Slow-Bus Cycle Synchronizer

This block sits between a processor running at several times the motherboard rate and a motherboard bus paced by a 7 MHz clock. When the processor starts a bus cycle, the block replays it on the motherboard with strobes aligned to 7 MHz edges. It always inserts wait states, and it only accepts the motherboard's data acknowledge once the cycle is old enough. The acknowledge is then returned to the processor at a fixed point in the slow clock. The block also grants the bus to a motherboard bus master, but only between cycles and on slow-clock edges.

Everything runs on the fast clock `clk`. The 7 MHz clock `sclk` is phase-locked to it and arrives as a level. A rising or falling slow edge is recognised in the fast cycle where `sclk` first shows its new value, and the state moves at that fast edge. Motherboard acknowledge and bus request are asynchronous, so each passes through a two-stage synchronizer that advances only on slow rising edges. All strobes are active low.

Rising edges are numbered from the one at which the processor's strobe is first seen low. That edge is A0. A1 is the first rising edge of the motherboard cycle, and so on. The write data-strobe delay `WR_DS_DELAY` and the earliest acknowledge sample `ACK_SAMPLE_CLK` are parameters.

Top module: `slowbus_bridge`

## Requirements
- R1: After reset, mb_as_n, mb_uds_n, mb_lds_n, cpu_dtack_n and mb_bg_n are 1, and mb_rw is 1 (1 = read, 0 = write).
- R2: A cycle arms at the slow rising edge A0 where cpu_as_n is low while idle. mb_as_n goes low at the next rising edge A1, never sooner, and only ever changes on slow rising edges (assertion) or falling edges (end).
- R3: mb_dtack_n passes through two flip-flops clocked by slow rising edges. It is acted on only at rising edge A3 or later. An acknowledge driven before A1 ends the cycle after A3 and not before.
- R4: The cycle ends on the first slow falling edge after the deciding rising edge. mb_as_n, mb_uds_n and mb_lds_n all go high at that edge, and cpu_dtack_n goes low at the same edge.
- R5: cpu_dtack_n stays low while cpu_as_n stays low, and no new motherboard cycle starts meanwhile. It returns high at the first fast clock edge at which cpu_as_n is high.
- R6: On a read (cpu_rw = 1), mb_uds_n and mb_lds_n take the processor's cpu_uds_n and cpu_lds_n values at A1, together with mb_as_n.
- R7: On a write (cpu_rw = 0), mb_rw is 0 from A1. The data strobes stay high until rising edge A(1+WR_DS_DELAY), with a default of 1 (so A2), and then take the processor's values.
- R8: mb_br_n is synchronized like R3. mb_bg_n goes low on a slow rising edge only while idle, three rising edges after the request is driven. When a request and an armable processor strobe meet at the same idle edge, the grant wins.
- R9: While the bus is granted, cpu_as_n is ignored and mb_as_n stays high. The grant drops three rising edges after mb_br_n returns high, and a waiting processor cycle arms at the next rising edge.
- R10: An acknowledge driven just after rising edge Ak, with k of 1 or more, ends the cycle at the falling edge after A(k+3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast processor clock |
| rst_n | input | 1 | Active-low reset |
| sclk | input | 1 | 7 MHz motherboard clock, phase-locked to clk |
| cpu_as_n | input | 1 | Processor address strobe |
| cpu_uds_n | input | 1 | Processor upper data strobe |
| cpu_lds_n | input | 1 | Processor lower data strobe |
| cpu_rw | input | 1 | Processor read (1) / write (0) |
| mb_dtack_n | input | 1 | Motherboard data acknowledge, asynchronous |
| mb_br_n | input | 1 | Motherboard bus request, asynchronous |
| mb_as_n | output | 1 | Retimed address strobe to the motherboard |
| mb_uds_n | output | 1 | Retimed upper data strobe |
| mb_lds_n | output | 1 | Retimed lower data strobe |
| mb_rw | output | 1 | Read/write to the motherboard |
| cpu_dtack_n | output | 1 | Acknowledge returned to the processor |
| mb_bg_n | output | 1 | Bus grant to the motherboard master |

## Verification
Each result is due at a known slow edge, counted from the edge at which its stimulus was driven. The motherboard strobe falls one rising edge after arming. An acknowledge ends the cycle at the falling edge that follows the third rising edge after it is driven, but never before A3. A grant appears or drops three rising edges after the request changes. cpu_dtack_n releases one fast clock after the processor's strobe rises. The bench has a helper that waits for the bench's own slow edge, then for the fast edge that registers it, and samples at the following falling edge of clk. Every check therefore falls exactly one registered edge after its cause. It also looks one edge early to see that nothing has moved yet.

// File: rtl/slowbus_pkg.sv
package slowbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_RUN,
        ST_TERM,
        ST_DONE,
        ST_GRANT
    } bus_state_e;

endpackage

// File: rtl/slowbus_edge_det.sv
module slowbus_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic rise_evt,
    output logic fall_evt
);
    logic sclk_d, sclk_q;

    always_comb sclk_d = sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_d;
    end

    assign rise_evt = sclk & ~sclk_q;
    assign fall_evt = ~sclk & sclk_q;
endmodule

// File: rtl/slowbus_in_sync.sv
module slowbus_in_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        for (int i = 0; i < STAGES; i++) stg_d[i] = stg_q[i];
        if (adv) begin
            stg_d[0] = async_in;
            for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '1;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/slowbus_cycle_fsm.sv
module slowbus_cycle_fsm
    import slowbus_pkg::*;
#(
    parameter int ACK_SAMPLE_CLK = 3,
    parameter int WR_DS_DELAY    = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_evt,
    input  logic fall_evt,
    input  logic cpu_as_n,
    input  logic cpu_uds_n,
    input  logic cpu_lds_n,
    input  logic cpu_rw,
    input  logic ack_s_n,
    input  logic br_s_n,
    output logic mb_as_n,
    output logic mb_uds_n,
    output logic mb_lds_n,
    output logic mb_rw,
    output logic cpu_dtack_n,
    output logic mb_bg_n
);
    localparam int CW = $clog2(ACK_SAMPLE_CLK + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(ACK_SAMPLE_CLK);
    localparam logic [CW-1:0] CNT_ACK  = CW'(ACK_SAMPLE_CLK - 1);
    localparam logic [CW-1:0] CNT_DS   = CW'(WR_DS_DELAY);
    localparam bit            DS_NOW   = (WR_DS_DELAY == 0);

    typedef struct packed {
        bus_state_e    st;
        logic [CW-1:0] cnt;
        logic          ds_on;
        logic          as_n;
        logic          uds_n;
        logic          lds_n;
        logic          rw;
        logic          dtack_n;
        logic          bg_n;
    } fsm_regs_t;

    localparam fsm_regs_t RESET_REGS = '{
        st: ST_IDLE, cnt: '0, ds_on: 1'b0, as_n: 1'b1, uds_n: 1'b1,
        lds_n: 1'b1, rw: 1'b1, dtack_n: 1'b1, bg_n: 1'b1
    };

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (rise_evt) begin
                    if (!br_s_n) begin
                        r_d.st   = ST_GRANT;
                        r_d.bg_n = 1'b0;
                    end else if (!cpu_as_n) begin
                        r_d.st = ST_ARM;
                    end
                end
            end
            ST_ARM: begin
                if (rise_evt) begin
                    r_d.st   = ST_RUN;
                    r_d.as_n = 1'b0;
                    r_d.cnt  = CW'(1);
                    r_d.rw   = cpu_rw;
                    if (cpu_rw || DS_NOW) begin
                        r_d.ds_on = 1'b1;
                        r_d.uds_n = cpu_uds_n;
                        r_d.lds_n = cpu_lds_n;
                    end
                end
            end
            ST_RUN: begin
                if (rise_evt) begin
                    if (r_q.cnt != CNT_MAX) r_d.cnt = r_q.cnt + CW'(1);
                    if (!r_q.ds_on && r_q.cnt == CNT_DS) begin
                        r_d.ds_on = 1'b1;
                        r_d.uds_n = cpu_uds_n;
                        r_d.lds_n = cpu_lds_n;
                    end
                    if (r_q.cnt >= CNT_ACK && !ack_s_n) r_d.st = ST_TERM;
                end
            end
            ST_TERM: begin
                if (fall_evt) begin
                    r_d.st      = ST_DONE;
                    r_d.as_n    = 1'b1;
                    r_d.uds_n   = 1'b1;
                    r_d.lds_n   = 1'b1;
                    r_d.ds_on   = 1'b0;
                    r_d.rw      = 1'b1;
                    r_d.dtack_n = 1'b0;
                end
            end
            ST_DONE: begin
                if (cpu_as_n) begin
                    r_d.st      = ST_IDLE;
                    r_d.dtack_n = 1'b1;
                end
            end
            ST_GRANT: begin
                if (rise_evt && br_s_n) begin
                    r_d.st   = ST_IDLE;
                    r_d.bg_n = 1'b1;
                end
            end
            default: r_d = RESET_REGS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_REGS;
        else        r_q <= r_d;
    end

    assign mb_as_n     = r_q.as_n;
    assign mb_uds_n    = r_q.uds_n;
    assign mb_lds_n    = r_q.lds_n;
    assign mb_rw       = r_q.rw;
    assign cpu_dtack_n = r_q.dtack_n;
    assign mb_bg_n     = r_q.bg_n;
endmodule

// File: rtl/slowbus_bridge.sv
module slowbus_bridge #(
    parameter int ACK_SAMPLE_CLK = 3,
    parameter int WR_DS_DELAY    = 1,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cpu_as_n,
    input  logic cpu_uds_n,
    input  logic cpu_lds_n,
    input  logic cpu_rw,
    input  logic mb_dtack_n,
    input  logic mb_br_n,
    output logic mb_as_n,
    output logic mb_uds_n,
    output logic mb_lds_n,
    output logic mb_rw,
    output logic cpu_dtack_n,
    output logic mb_bg_n
);
    logic       rise_evt, fall_evt;
    logic [1:0] mb_sync;

    slowbus_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    slowbus_in_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (rise_evt),
        .async_in ({mb_br_n, mb_dtack_n}),
        .sync_out (mb_sync)
    );

    slowbus_cycle_fsm #(
        .ACK_SAMPLE_CLK (ACK_SAMPLE_CLK),
        .WR_DS_DELAY    (WR_DS_DELAY)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_evt    (rise_evt),
        .fall_evt    (fall_evt),
        .cpu_as_n    (cpu_as_n),
        .cpu_uds_n   (cpu_uds_n),
        .cpu_lds_n   (cpu_lds_n),
        .cpu_rw      (cpu_rw),
        .ack_s_n     (mb_sync[0]),
        .br_s_n      (mb_sync[1]),
        .mb_as_n     (mb_as_n),
        .mb_uds_n    (mb_uds_n),
        .mb_lds_n    (mb_lds_n),
        .mb_rw       (mb_rw),
        .cpu_dtack_n (cpu_dtack_n),
        .mb_bg_n     (mb_bg_n)
    );
endmodule

// File: rtl/slowbus_bridge_chk.sv
module slowbus_bridge_chk #(
    parameter int ACK_SAMPLE_CLK = 3,
    parameter int WR_DS_DELAY    = 1,
    parameter int SYNC_STAGES    = 2
) (
    input logic clk,
    input logic rst_n,
    input logic sclk,
    input logic cpu_as_n,
    input logic cpu_uds_n,
    input logic cpu_lds_n,
    input logic cpu_rw,
    input logic mb_dtack_n,
    input logic mb_br_n,
    input logic mb_as_n,
    input logic mb_uds_n,
    input logic mb_lds_n,
    input logic mb_rw,
    input logic cpu_dtack_n,
    input logic mb_bg_n
);
    logic        chk_sclk_q;
    logic [7:0]  low_rises_q;
    logic        chk_rise, chk_fall;

    assign chk_rise = sclk & ~chk_sclk_q;
    assign chk_fall = ~sclk & chk_sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_sclk_q  <= 1'b0;
            low_rises_q <= '0;
        end else begin
            chk_sclk_q <= sclk;
            if (mb_as_n)                        low_rises_q <= '0;
            else if (chk_rise && low_rises_q != 8'hFF) low_rises_q <= low_rises_q + 8'd1;
        end
    end

    AST_AS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mb_as_n) |-> $past(chk_rise)) else $error("AST_AS_ON_RISE"); // R2
    AST_MIN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mb_as_n) |-> (low_rises_q >= 8'(ACK_SAMPLE_CLK - 1))) else $error("AST_MIN_WAIT"); // R3
    AST_END_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mb_as_n) |-> $past(chk_fall)) else $error("AST_END_ON_FALL"); // R4
    AST_ACK_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_dtack_n) |-> ($rose(mb_as_n) && mb_uds_n && mb_lds_n)) else $error("AST_ACK_WITH_END"); // R4
    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_dtack_n && !cpu_as_n) |=> !cpu_dtack_n) else $error("AST_ACK_HOLD"); // R5
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_dtack_n && cpu_as_n) |=> cpu_dtack_n) else $error("AST_ACK_RELEASE"); // R5
    AST_WR_DS_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((WR_DS_DELAY > 0) && $fell(mb_as_n) && !mb_rw) |-> (mb_uds_n && mb_lds_n)) else $error("AST_WR_DS_LATE"); // R7
    AST_GRANT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mb_bg_n) |-> $past(chk_rise)) else $error("AST_GRANT_ON_RISE"); // R8
    AST_GRANT_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mb_bg_n |-> (mb_as_n && cpu_dtack_n)) else $error("AST_GRANT_NO_CYCLE"); // R9
endmodule

bind slowbus_bridge slowbus_bridge_chk #(
    .ACK_SAMPLE_CLK (ACK_SAMPLE_CLK),
    .WR_DS_DELAY    (WR_DS_DELAY),
    .SYNC_STAGES    (SYNC_STAGES)
) u_chk (.*);

// File: tb/tb_slowbus_bridge.sv
`timescale 1ns/1ps
module tb_slowbus_bridge;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cpu_as_n = 1'b1, cpu_uds_n = 1'b1, cpu_lds_n = 1'b1, cpu_rw = 1'b1;
    logic mb_dtack_n = 1'b1, mb_br_n = 1'b1;
    logic mb_as_n, mb_uds_n, mb_lds_n, mb_rw, cpu_dtack_n, mb_bg_n;

    int checks = 0;
    int errors = 0;
    logic [2:0] ph = '0;

    always #10 clk = ~clk;

    // Slow clock: 8 fast clocks per period, changed only on falling clk
    always @(negedge clk) begin
        ph   <= ph + 3'd1;
        sclk <= (ph + 3'd1) < 3'd4;
    end

    slowbus_bridge dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk),
        .cpu_as_n(cpu_as_n), .cpu_uds_n(cpu_uds_n), .cpu_lds_n(cpu_lds_n), .cpu_rw(cpu_rw),
        .mb_dtack_n(mb_dtack_n), .mb_br_n(mb_br_n),
        .mb_as_n(mb_as_n), .mb_uds_n(mb_uds_n), .mb_lds_n(mb_lds_n), .mb_rw(mb_rw),
        .cpu_dtack_n(cpu_dtack_n), .mb_bg_n(mb_bg_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic rise_s();
        @(posedge sclk); @(posedge clk); @(negedge clk);
    endtask

    task automatic fall_s();
        @(negedge sclk); @(posedge clk); @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 mb_as_n",     mb_as_n, 1'b1);
        chk("R1 mb_uds_n",    mb_uds_n, 1'b1);
        chk("R1 mb_lds_n",    mb_lds_n, 1'b1);
        chk("R1 mb_rw",       mb_rw, 1'b1);
        chk("R1 cpu_dtack_n", cpu_dtack_n, 1'b1);
        chk("R1 mb_bg_n",     mb_bg_n, 1'b1);
    endtask

    task automatic finish_cycle(input string req);
        for (int i = 0; i < 3; i++) begin
            rise_s();
            chk({req, " R5 dtack held"}, cpu_dtack_n, 1'b0);
            chk({req, " R5 no new cycle"}, mb_as_n, 1'b1);
        end
        cpu_as_n = 1'b1; cpu_uds_n = 1'b1; cpu_lds_n = 1'b1; cpu_rw = 1'b1;
        mb_dtack_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk({req, " R5 dtack release"}, cpu_dtack_n, 1'b1);
        for (int i = 0; i < 3; i++) rise_s();
    endtask

    // Read with an early acknowledge
    task automatic t_read_early_ack();
        rise_s();
        cpu_as_n = 1'b0; cpu_uds_n = 1'b0; cpu_lds_n = 1'b1; cpu_rw = 1'b1;
        mb_dtack_n = 1'b0;
        rise_s(); // A0
        chk("R2 no strobe at arm", mb_as_n, 1'b1);
        rise_s(); // A1
        chk("R2 strobe at A1", mb_as_n, 1'b0);
        chk("R6 uds copied", mb_uds_n, 1'b0);
        chk("R6 lds copied", mb_lds_n, 1'b1);
        chk("R6 rw read", mb_rw, 1'b1);
        rise_s(); fall_s(); // A2 and its falling edge
        chk("R3 early ack ignored as", mb_as_n, 1'b0);
        chk("R3 early ack ignored dtack", cpu_dtack_n, 1'b1);
        rise_s(); // A3
        chk("R4 not ended at rise", mb_as_n, 1'b0);
        fall_s();
        chk("R4 as ends on fall", mb_as_n, 1'b1);
        chk("R4 uds ends", mb_uds_n, 1'b1);
        chk("R4 dtack asserted", cpu_dtack_n, 1'b0);
        finish_cycle("read");
    endtask

    // Write with delayed strobes and a late acknowledge
    task automatic t_write_late_ack();
        rise_s();
        cpu_as_n = 1'b0; cpu_uds_n = 1'b0; cpu_lds_n = 1'b0; cpu_rw = 1'b0;
        rise_s(); // A0
        rise_s(); // A1
        chk("R7 as at A1", mb_as_n, 1'b0);
        chk("R7 rw write", mb_rw, 1'b0);
        chk("R7 uds held back", mb_uds_n, 1'b1);
        chk("R7 lds held back", mb_lds_n, 1'b1);
        rise_s(); // A2
        chk("R7 uds at A2", mb_uds_n, 1'b0);
        chk("R7 lds at A2", mb_lds_n, 1'b0);
        rise_s(); rise_s(); // A4
        mb_dtack_n = 1'b0;
        rise_s(); rise_s(); fall_s(); // A6 and fall
        chk("R10 not ended after A6", mb_as_n, 1'b0);
        chk("R10 no dtack after A6", cpu_dtack_n, 1'b1);
        rise_s(); // A7
        chk("R10 not ended at A7 rise", mb_as_n, 1'b0);
        fall_s();
        chk("R10 ended after A7", mb_as_n, 1'b1);
        chk("R10 dtack after A7", cpu_dtack_n, 1'b0);
        chk("R4 rw restored", mb_rw, 1'b1);
        finish_cycle("write");
    endtask

    // Grant beats a pending cycle, then the cycle runs after release
    task automatic t_grant();
        rise_s(); // Ra
        mb_br_n = 1'b0;
        rise_s(); rise_s(); // Ra+2
        chk("R8 no grant yet", mb_bg_n, 1'b1);
        cpu_as_n = 1'b0; cpu_uds_n = 1'b0; cpu_lds_n = 1'b0; cpu_rw = 1'b1;
        rise_s(); // Ra+3
        chk("R8 grant given", mb_bg_n, 1'b0);
        chk("R8 grant beats cpu", mb_as_n, 1'b1);
        for (int i = 0; i < 4; i++) begin
            rise_s();
            chk("R9 cpu ignored while granted", mb_as_n, 1'b1);
        end
        mb_br_n = 1'b1; // after Rb
        rise_s(); rise_s();
        chk("R9 grant still held", mb_bg_n, 1'b0);
        rise_s(); // Rb+3
        chk("R9 grant dropped", mb_bg_n, 1'b1);
        chk("R9 no strobe at drop", mb_as_n, 1'b1);
        rise_s(); // Rb+4 arm
        chk("R9 arm edge", mb_as_n, 1'b1);
        rise_s(); // Rb+5
        chk("R9 cycle starts", mb_as_n, 1'b0);
        mb_dtack_n = 1'b0;
        for (int i = 0; i < 40 && cpu_dtack_n; i++) @(negedge clk);
        chk("R9 cycle completes", cpu_dtack_n, 1'b0);
        finish_cycle("grant");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_early_ack();
        t_write_late_ack();
        t_grant();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule